// File: doc/BRIEF.md
# Exclusive Virtual-Channel Allocator

This block is the virtual-channel allocation stage for one output port of an ingress-queued wormhole router. Several input ports present head-flit requests, each tagged with a flow identifier and with the result of a flow-ownership lookup. The lookup reports whether that flow still has flits in one of the downstream virtual channels, and if so which one. The allocator grants each request a downstream VC so that a single flow never sits in two downstream VCs at the same time. A flow that has no downstream VC takes the lowest free VC. A flow that already has one is locked to it and waits if that VC is busy, even when other VCs are idle.

Requests use a valid/ready handshake. A requester raises `req_valid` with its flow and lookup result and keeps them stable until `req_ready` is high in the same cycle. That cycle is the grant, and `gnt_vc` carries the chosen VC. A low `req_ready` is a stall: the request is evaluated again on the next cycle. After a grant, the input keeps its VC in a per-input register and shows it on `hold_vc`. Body and tail flits use that cached VC without arbitration. When the switch reports the tail flit of that input as forwarded, the register is cleared.

Top module: `exdvc_alloc`

## Requirements
- R1: After reset no input holds a VC (`hold_valid` all zero), the round-robin pointer is at input 0, and no request is granted.
- R2: A request with no ownership hit, with `tbl_full` low and with at least one available and unclaimed VC, is granted the lowest-numbered such VC. VC numbers are binary indices from 0 to N_VC-1.
- R3: A request with an ownership hit is granted exactly `lk_vc` when that VC is available and unclaimed, even if a lower-numbered VC is free.
- R4: A request with an ownership hit whose VC is unavailable or already claimed in that cycle is not granted, even when other VCs are free.
- R5: A request with no ownership hit stalls when no VC is available and unclaimed.
- R6: A request with no ownership hit stalls while `tbl_full` is high. A request with a hit is not affected by `tbl_full`.
- R7: A VC is available only if its `vc_credit_ok` bit is 1 and no input currently holds it as a cached assignment.
- R8: A grant sets the input's `hold_valid` on the next cycle, with `hold_vc` equal to the granted VC. The assignment stays unchanged through forwarded body flits. New requests from an input that holds a VC are ignored, meaning `req_ready` stays low.
- R9: A forwarded tail flit (`fwd_valid` and `fwd_tail` both 1) on a holding input clears its hold on the next cycle. The VC becomes available in that same next cycle.
- R10: Requests are served in round-robin order, starting at the pointer and going through increasing input index with wrap. At most one request is granted per VC per cycle. After any grant, the pointer moves to one past the first input served in that cycle.
- R11: In a cycle in which a request of some flow has already been granted earlier in the serving order, a later request of the same flow is not granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N_IN | Head-flit request per input |
| req_flow | input | N_IN*FLOW_W | Flow identifier per input |
| lk_hit | input | N_IN | Ownership lookup: the flow already occupies a downstream VC |
| lk_vc | input | N_IN*VCW | Ownership lookup: the VC that the flow occupies |
| tbl_full | input | 1 | Ownership table has no free slot |
| vc_credit_ok | input | N_VC | Downstream VC has at least one credit |
| fwd_valid | input | N_IN | A flit of this input was forwarded this cycle |
| fwd_tail | input | N_IN | The forwarded flit is a tail |
| req_ready | output | N_IN | Grant, valid/ready handshake with req_valid |
| gnt_vc | output | N_IN*VCW | Granted VC per input (zero when not granted) |
| hold_valid | output | N_IN | Input has a cached VC assignment |
| hold_vc | output | N_IN*VCW | Cached VC per input |

## Verification
The bench targets a flow with an owned VC that is busy while lower VCs are idle. A design that falls back to a free VC in that case would place one flow in two VCs and break ordering. It drives two same-flow heads with no ownership entry in one cycle, which a design without the in-cycle flow check would scatter over two VCs. It also sends requests from inputs that already hold a VC, releases a VC by a tail and has it reused in the next cycle, and lets all inputs contend at once. A wrong pointer update shows up there as a changed service order, and a missing claim mask shows up as two grants of one VC.

// File: rtl/exdvc_pkg.sv
package exdvc_pkg;
  // Wrap an index into the range [0, n).
  function automatic int unsigned wrap_idx(input int unsigned a, input int unsigned n);
    return (a >= n) ? (a - n) : a;
  endfunction
endpackage

// File: rtl/exdvc_hold_reg.sv
module exdvc_hold_reg #(
  parameter int VCW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           set,
  input  logic [VCW-1:0] set_vc,
  input  logic           clr,
  output logic           valid,
  output logic [VCW-1:0] vc
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      vc    <= '0;
    end else if (clr) begin
      valid <= 1'b0;
    end else if (set) begin
      valid <= 1'b1;
      vc    <= set_vc;
    end
  end
endmodule

// File: rtl/exdvc_rr_ptr.sv
module exdvc_rr_ptr #(
  parameter int N_IN = 4,
  parameter int IW   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic [IW-1:0] served,
  output logic [IW-1:0] ptr
);
  logic [IW-1:0] nxt;
  assign nxt = (int'(served) == N_IN - 1) ? '0 : served + IW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)   ptr <= '0;
    else if (adv) ptr <= nxt;
  end
endmodule

// File: rtl/exdvc_alloc.sv
module exdvc_alloc #(
  parameter int N_IN   = 4,
  parameter int N_VC   = 4,
  parameter int FLOW_W = 4,
  localparam int VCW   = (N_VC > 1) ? $clog2(N_VC) : 1,
  localparam int IW    = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_IN-1:0]        req_valid,
  input  logic [N_IN*FLOW_W-1:0] req_flow,
  input  logic [N_IN-1:0]        lk_hit,
  input  logic [N_IN*VCW-1:0]    lk_vc,
  input  logic                   tbl_full,
  input  logic [N_VC-1:0]        vc_credit_ok,
  input  logic [N_IN-1:0]        fwd_valid,
  input  logic [N_IN-1:0]        fwd_tail,
  output logic [N_IN-1:0]        req_ready,
  output logic [N_IN*VCW-1:0]    gnt_vc,
  output logic [N_IN-1:0]        hold_valid,
  output logic [N_IN*VCW-1:0]    hold_vc
);
  import exdvc_pkg::*;

  logic [IW-1:0]   ptr;
  logic [VCW-1:0]  hvc   [N_IN];
  logic [VCW-1:0]  gvc   [N_IN];
  logic [N_VC-1:0] busy, avail;
  logic            any_win;
  logic [IW-1:0]   first_pos;

  // Cached per-input assignments.
  for (genvar i = 0; i < N_IN; i++) begin : g_hold
    exdvc_hold_reg #(.VCW(VCW)) u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .set    (req_ready[i]),
      .set_vc (gvc[i]),
      .clr    (hold_valid[i] & fwd_valid[i] & fwd_tail[i]),
      .valid  (hold_valid[i]),
      .vc     (hvc[i])
    );
    assign hold_vc[i*VCW +: VCW] = hvc[i];
    assign gnt_vc[i*VCW +: VCW]  = gvc[i];
  end

  // A VC held by any input wormhole is not available.
  always_comb begin
    busy = '0;
    for (int i = 0; i < N_IN; i++)
      if (hold_valid[i]) busy[hvc[i]] = 1'b1;
  end
  assign avail = vc_credit_ok & ~busy;

  // Serve inputs in rotated order. For each one the free search and the
  // owned-VC check run side by side, and a final mux picks the result.
  always_comb begin
    logic [N_VC-1:0] claimed;
    logic [N_IN-1:0] won;
    int unsigned     pos;
    logic            clash, free_ok, own_ok, ok;
    logic [VCW-1:0]  free_vc, own_vc, pick;
    claimed   = '0;
    won       = '0;
    req_ready = '0;
    any_win   = 1'b0;
    first_pos = '0;
    for (int i = 0; i < N_IN; i++) gvc[i] = '0;
    for (int k = 0; k < N_IN; k++) begin
      pos   = wrap_idx(int'(ptr) + k, N_IN);
      clash = 1'b0;
      for (int j = 0; j < N_IN; j++)
        if (won[j] && req_flow[j*FLOW_W +: FLOW_W] == req_flow[pos*FLOW_W +: FLOW_W])
          clash = 1'b1;
      free_ok = 1'b0;
      free_vc = '0;
      for (int v = N_VC - 1; v >= 0; v--)
        if (avail[v] && !claimed[v]) begin
          free_ok = 1'b1;
          free_vc = VCW'(v);
        end
      own_vc = lk_vc[pos*VCW +: VCW];
      own_ok = avail[own_vc] && !claimed[own_vc];
      ok     = lk_hit[pos] ? own_ok : (free_ok && !tbl_full);
      pick   = lk_hit[pos] ? own_vc : free_vc;
      if (req_valid[pos] && !hold_valid[pos] && !clash && ok) begin
        req_ready[pos] = 1'b1;
        won[pos]       = 1'b1;
        gvc[pos]       = pick;
        claimed[pick]  = 1'b1;
        if (!any_win) begin
          any_win   = 1'b1;
          first_pos = IW'(pos);
        end
      end
    end
  end

  exdvc_rr_ptr #(.N_IN(N_IN), .IW(IW)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv    (any_win),
    .served (first_pos),
    .ptr    (ptr)
  );
endmodule

// File: rtl/exdvc_alloc_chk.sv
module exdvc_alloc_chk #(
  parameter int N_IN   = 4,
  parameter int N_VC   = 4,
  parameter int FLOW_W = 4,
  localparam int VCW   = (N_VC > 1) ? $clog2(N_VC) : 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [N_IN-1:0]        req_valid,
  input logic [N_IN*FLOW_W-1:0] req_flow,
  input logic [N_IN-1:0]        lk_hit,
  input logic [N_IN*VCW-1:0]    lk_vc,
  input logic                   tbl_full,
  input logic [N_VC-1:0]        vc_credit_ok,
  input logic [N_IN-1:0]        fwd_valid,
  input logic [N_IN-1:0]        fwd_tail,
  input logic [N_IN-1:0]        req_ready,
  input logic [N_IN*VCW-1:0]    gnt_vc,
  input logic [N_IN-1:0]        hold_valid,
  input logic [N_IN*VCW-1:0]    hold_vc
);
  logic dup_vc, bad_avail;
  always_comb begin
    logic [N_VC-1:0] seen;
    seen = '0;
    dup_vc = 1'b0;
    bad_avail = 1'b0;
    for (int i = 0; i < N_IN; i++) begin
      if (req_ready[i]) begin
        if (seen[gnt_vc[i*VCW +: VCW]]) dup_vc = 1'b1;
        seen[gnt_vc[i*VCW +: VCW]] = 1'b1;
        if (!vc_credit_ok[gnt_vc[i*VCW +: VCW]]) bad_avail = 1'b1;
        for (int j = 0; j < N_IN; j++)
          if (hold_valid[j] && hold_vc[j*VCW +: VCW] == gnt_vc[i*VCW +: VCW])
            bad_avail = 1'b1;
      end
    end
  end

  p_one_grant_per_vc_r10: assert property (@(posedge clk) disable iff (!rst_n) !dup_vc);
  p_only_available_r7:    assert property (@(posedge clk) disable iff (!rst_n) !bad_avail);

  for (genvar i = 0; i < N_IN; i++) begin : g_in
    p_owned_vc_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready[i] && lk_hit[i]) |-> gnt_vc[i*VCW +: VCW] == lk_vc[i*VCW +: VCW]);
    p_owned_nocredit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_hit[i] && !vc_credit_ok[lk_vc[i*VCW +: VCW]]) |-> !req_ready[i]);
    p_table_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!lk_hit[i] && tbl_full) |-> !req_ready[i]);
    p_grant_sets_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready[i] |=> (hold_valid[i] && hold_vc[i*VCW +: VCW] == $past(gnt_vc[i*VCW +: VCW])));
    p_hold_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_valid[i] && !(fwd_valid[i] && fwd_tail[i])) |=>
        (hold_valid[i] && $stable(hold_vc[i*VCW +: VCW])));
    p_holding_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
      hold_valid[i] |-> !req_ready[i]);
    p_tail_releases_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_valid[i] && fwd_valid[i] && fwd_tail[i]) |=> !hold_valid[i]);
  end
endmodule

bind exdvc_alloc exdvc_alloc_chk #(.N_IN(N_IN), .N_VC(N_VC), .FLOW_W(FLOW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_flow(req_flow),
  .lk_hit(lk_hit), .lk_vc(lk_vc), .tbl_full(tbl_full), .vc_credit_ok(vc_credit_ok),
  .fwd_valid(fwd_valid), .fwd_tail(fwd_tail), .req_ready(req_ready), .gnt_vc(gnt_vc),
  .hold_valid(hold_valid), .hold_vc(hold_vc)
);

// File: tb/exdvc_alloc_bench.sv
module exdvc_alloc_bench;
  localparam int CLK_P = 10;
  localparam int N  = 4;
  localparam int NV = 4;
  localparam int FW = 4;
  localparam int VW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]    req_valid = '0;
  logic [N*FW-1:0] req_flow = '0;
  logic [N-1:0]    lk_hit = '0;
  logic [N*VW-1:0] lk_vc = '0;
  logic            tbl_full = 1'b0;
  logic [NV-1:0]   vc_credit_ok = '1;
  logic [N-1:0]    fwd_valid = '0;
  logic [N-1:0]    fwd_tail = '0;
  logic [N-1:0]    req_ready;
  logic [N*VW-1:0] gnt_vc;
  logic [N-1:0]    hold_valid;
  logic [N*VW-1:0] hold_vc;

  always #(CLK_P/2) clk = ~clk;

  exdvc_alloc #(.N_IN(N), .N_VC(NV), .FLOW_W(FW)) u_exdvc_alloc (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_flow(req_flow),
    .lk_hit(lk_hit), .lk_vc(lk_vc), .tbl_full(tbl_full), .vc_credit_ok(vc_credit_ok),
    .fwd_valid(fwd_valid), .fwd_tail(fwd_tail), .req_ready(req_ready), .gnt_vc(gnt_vc),
    .hold_valid(hold_valid), .hold_vc(hold_vc)
  );

  int n_vec = 0, n_bad = 0;
  bit done = 0;
  string cur_req = "R1";

  // Reference state
  int m_hv[N], m_hvc[N], m_ptr;
  int e_rdy[N], e_vc[N];

  task automatic chk(string what, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin m_hv[i] = 0; m_hvc[i] = 0; end
    m_ptr = 0;
  endtask

  task automatic model_eval();
    int av[NV]; int cl[NV]; int won[N];
    for (int v = 0; v < NV; v++) begin av[v] = vc_credit_ok[v]; cl[v] = 0; end
    for (int i = 0; i < N; i++) begin
      if (m_hv[i] != 0) av[m_hvc[i]] = 0;
      won[i] = 0; e_rdy[i] = 0; e_vc[i] = 0;
    end
    for (int k = 0; k < N; k++) begin
      int i; int same; int target;
      i = (m_ptr + k) % N;
      target = -1;
      same = 0;
      for (int j = 0; j < N; j++)
        if (won[j] != 0 && req_flow[j*FW +: FW] == req_flow[i*FW +: FW]) same = 1;
      if (req_valid[i] && m_hv[i] == 0 && same == 0) begin
        if (lk_hit[i]) begin
          int o; o = int'(lk_vc[i*VW +: VW]);
          if (av[o] != 0 && cl[o] == 0) target = o;
        end else if (!tbl_full) begin
          for (int v = 0; v < NV; v++)
            if (target < 0 && av[v] != 0 && cl[v] == 0) target = v;
        end
      end
      if (target >= 0) begin
        e_rdy[i] = 1; e_vc[i] = target; cl[target] = 1; won[i] = 1;
      end
    end
  endtask

  task automatic model_update();
    int first; first = -1;
    for (int k = 0; k < N; k++)
      if (first < 0 && e_rdy[(m_ptr + k) % N] != 0) first = (m_ptr + k) % N;
    for (int i = 0; i < N; i++) begin
      if (m_hv[i] != 0 && fwd_valid[i] && fwd_tail[i]) m_hv[i] = 0;
      else if (e_rdy[i] != 0) begin m_hv[i] = 1; m_hvc[i] = e_vc[i]; end
    end
    if (first >= 0) m_ptr = (first + 1) % N;
  endtask

  task automatic cycle();
    @(negedge clk);
    model_eval();
    for (int i = 0; i < N; i++) begin
      chk($sformatf("req_ready[%0d]", i), int'(req_ready[i]), e_rdy[i]);
      if (e_rdy[i] != 0) chk($sformatf("gnt_vc[%0d]", i), int'(gnt_vc[i*VW +: VW]), e_vc[i]);
      chk($sformatf("hold_valid[%0d]", i), int'(hold_valid[i]), m_hv[i]);
      if (m_hv[i] != 0) chk($sformatf("hold_vc[%0d]", i), int'(hold_vc[i*VW +: VW]), m_hvc[i]);
    end
    @(posedge clk);
    if (rst_n) model_update(); else model_reset();
    #1;
  endtask

  task automatic quiet();
    req_valid = '0; lk_hit = '0; tbl_full = 1'b0; vc_credit_ok = '1;
    fwd_valid = '0; fwd_tail = '0;
  endtask

  task automatic ask(int i, int flow, int hit, int vc);
    req_valid[i] = 1'b1;
    req_flow[i*FW +: FW] = FW'(flow);
    lk_hit[i] = hit[0];
    lk_vc[i*VW +: VW] = VW'(vc);
  endtask

  task automatic drain();
    quiet(); fwd_valid = '1; fwd_tail = '1; cycle(); quiet();
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL %s watchdog: actual timeout expected completion", cur_req);
      summary();
      $finish;
    end
  end

  initial begin
    model_reset();
    #1;
    cur_req = "R1"; cycle(); cycle();
    rst_n = 1'b1;
    cycle();
    // R2: fresh flow takes lowest free VC
    cur_req = "R2"; ask(0, 1, 0, 0); cycle(); quiet();
    // R7: held VC0 and no-credit VC2 are skipped
    cur_req = "R7"; ask(1, 2, 0, 0); cycle(); quiet();
    vc_credit_ok = 4'b1011; ask(2, 3, 0, 0); cycle(); quiet();
    // R8: request while holding is ignored, body flit keeps hold
    cur_req = "R8"; ask(0, 7, 0, 0); fwd_valid[0] = 1'b1; cycle(); quiet(); cycle();
    // R9: tail releases, VC reused next cycle
    cur_req = "R9"; fwd_valid[0] = 1'b1; fwd_tail[0] = 1'b1; cycle(); quiet();
    ask(3, 5, 0, 0); cycle(); quiet();
    drain();
    // R3: owned VC wins over lower free VCs
    cur_req = "R3"; ask(1, 4, 1, 2); cycle(); quiet();
    // R4: owned VC busy -> stall although VC0 free
    cur_req = "R4"; ask(2, 4, 1, 2); cycle(); cycle(); quiet();
    vc_credit_ok = 4'b0111; ask(0, 6, 1, 3); cycle(); quiet();
    drain();
    // R5: nothing available
    cur_req = "R5"; vc_credit_ok = '0; ask(0, 1, 0, 0); cycle(); quiet();
    // R6: table full stalls misses, not hits
    cur_req = "R6"; tbl_full = 1'b1; ask(0, 1, 0, 0); ask(1, 2, 1, 3); cycle(); quiet();
    drain();
    // R10: all inputs contend, order follows pointer
    cur_req = "R10"; for (int i = 0; i < N; i++) ask(i, 8 + i, 0, 0); cycle(); quiet();
    drain();
    ask(0, 1, 0, 0); ask(1, 2, 1, 0); cycle(); quiet(); drain();
    // R11: two same-flow misses in one cycle
    cur_req = "R11"; ask(1, 9, 0, 0); ask(2, 9, 0, 0); cycle(); quiet();
    ask(2, 9, 1, 0); cycle(); quiet();
    drain();
    // Mixed traffic
    cur_req = "R10";
    for (int c = 0; c < 3000; c++) begin
      for (int i = 0; i < N; i++) begin
        ask(i, $urandom_range(0, 3), ($urandom_range(0, 3) == 0) ? 1 : 0, $urandom_range(0, NV - 1));
        req_valid[i] = ($urandom_range(0, 2) != 0);
        fwd_valid[i] = $urandom_range(0, 1) != 0;
        fwd_tail[i]  = $urandom_range(0, 2) == 0;
      end
      tbl_full = ($urandom_range(0, 7) == 0);
      vc_credit_ok = NV'($urandom_range(0, 15)) | NV'($urandom_range(0, 15));
      cycle();
    end
    done = 1;
    summary();
    $finish;
  end
endmodule